// File: doc/BRIEF.md
# Multi-ring notification writer

This block collects event requests from several compute engines and turns each one into a 16-byte notification record. Every record is written into one of up to ten circular rings held in system memory, each ring owned by software, through a single write master that carries one address, one 128-bit data word and a separate write response. A small register port programs each ring's location, size, consumer position and usage threshold, and returns the producer position that the block keeps.

Every record carries a payload, a 5-bit type code, two overflow flags, a phase bit and a 64-bit timestamp. The phase bit inverts each time a ring's write position wraps, so a consumer can find fresh records by watching that bit alone. The timestamp comes from a free-running counter that adds a programmable step every clock, so it can count real time rather than cycles. When a ring is full it either stalls the producer or overwrites old entries, selected per ring. Level interrupt outputs report a stalled full ring, a write aimed at a disabled ring, a write-response error and a ring that has reached its threshold.

Top module: `nq_ring_writer`

## Requirements
- R1: A record is 128 bits: [23:0] low payload, [28:24] type code, bit 29 overwrite flag, bit 30 stall flag, bit 31 phase, [63:32] high payload, [127:64] timestamp.
- R2: Ring i has registers at byte offset 0x100 + 40*i: base low +0x00, base high +0x04, size in bytes +0x08 (entry count E = size/16), head +0x0c, tail +0x10 (read-only), threshold +0x14; head and tail count entries. A record is written to base + 16*tail, and tail then becomes (tail+1) mod E once the write response arrives.
- R3: The phase bit of a ring is 1 after reset and inverts each time that ring's tail wraps from E-1 to 0; each record carries the phase in force when it was accepted.
- R4: The enable mask at 0x000 resets to 0x3ff (bit i enables ring i). A request to a disabled ring, or to a ring number of 10 or more, is accepted and dropped: no memory write, tail unchanged, status bit 1 set.
- R5: Occupancy is (tail - head) mod E and a ring is full at E-1 entries. With bit i of 0x004 clear, a request to full ring i is held unaccepted, status bit 0 is set and the ring number is placed in 0x010; once software moves the head the request is accepted and the next record on that ring has bit 30 set.
- R6: With bit i of 0x004 set, a request to full ring i is written anyway, tail advances past head, and that record has bit 29 set.
- R7: A write response with error sets status bit 4 and stores the record address in 0x014 (low) and 0x018 (high); the tail still advances.
- R8: After a completed write, if the ring's threshold is nonzero and occupancy is at least the threshold, interrupt bit 6 asserts; a software write to that ring's head clears it.
- R9: A 64-bit timestamp resets to 0 and adds the step at 0x008 (reset value 1) every clock; it reads at 0x01C/0x020, and each record stamps the counter value of its acceptance cycle.
- R10: Among simultaneous requesters the lowest index wins; a requester holds valid until it sees ready, and at most one ready is high.
- R11: Only one record is in flight: the write is held with stable address and data until accepted, and no request is accepted until its response returns.
- R12: Status at 0x00C holds sticky bits 0, 1 and 4, cleared by writing 1; irq_o carries them at those positions with bit 6 from R8 and all other bits zero.
- R13: After reset every tail and head is 0 and status and interrupts are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| req_valid | input | N_SRC | request valid per engine |
| req_ready | output | N_SRC | request accepted per engine |
| req_ring | input | N_SRC x 4 | target ring per engine |
| req_kind | input | N_SRC x 5 | record type code per engine |
| req_pay_lo | input | N_SRC x 24 | low payload per engine |
| req_pay_hi | input | N_SRC x 32 | high payload per engine |
| wr_valid | output | 1 | memory write request |
| wr_ready | input | 1 | memory write accepted |
| wr_addr | output | 64 | byte address of the record |
| wr_data | output | 128 | record contents |
| rsp_valid | input | 1 | write response |
| rsp_err | input | 1 | write response carries an error |
| reg_we | input | 1 | register write strobe |
| reg_addr | input | RA_W | register byte address |
| reg_wdata | input | 32 | register write data |
| reg_rdata | output | 32 | register read data (combinational) |
| irq_o | output | 9 | level interrupt vector |

## Verification
The hardest state to reach from the ports is a ring that is genuinely full, since software must leave head behind while records are written and the full point differs per ring size. The bench first sweeps every ring with a different entry count through two full wraps while consuming each record, which leaves tail and head at a known index, then fills chosen rings without consuming until the stall or overwrite point, and releases a stall by moving the head. Threshold, disabled-ring and response-error cases are driven from that same known state, and expected addresses, phases and flags are computed from the entry count alone.

// File: rtl/nq_pkg.sv
package nq_pkg;

  localparam int REC_BYTES = 16;

  typedef struct packed {
    logic [63:0] stamp;
    logic [31:0] pay_hi;
    logic        phase;
    logic        stall_flag;
    logic        ovw_flag;
    logic [4:0]  kind;
    logic [23:0] pay_lo;
  } nq_rec_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_RESP
  } nq_state_e;

  // entries held between consumer and producer, modulo the ring length
  function automatic logic [31:0] ring_occ(input logic [31:0] tl,
                                           input logic [31:0] hd,
                                           input logic [31:0] ents);
    if (tl >= hd) return tl - hd;
    return tl + ents - hd;
  endfunction

  // producer position after one record
  function automatic logic [31:0] ring_next(input logic [31:0] tl,
                                            input logic [31:0] ents);
    if (tl + 32'd1 >= ents) return 32'd0;
    return tl + 32'd1;
  endfunction

endpackage

// File: rtl/nq_prio_arb.sv
module nq_prio_arb #(
  parameter int N  = 3,
  localparam int SW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [SW-1:0] idx,
  output logic          any
);
  always_comb begin
    gnt = '0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        gnt    = '0;
        gnt[i] = 1'b1;
        idx    = SW'(i);
      end
    end
    any = |req;
  end
endmodule

// File: rtl/nq_ring_ctx.sv
module nq_ring_ctx
  import nq_pkg::*;
#(
  parameter int IDX_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      wdata,
  input  logic             we_base_lo,
  input  logic             we_base_hi,
  input  logic             we_size,
  input  logic             we_head,
  input  logic             we_thr,
  input  logic             adv,
  input  logic             stall_mark,
  output logic [63:0]      base,
  output logic [IDX_W-1:0] ents,
  output logic [IDX_W-1:0] head,
  output logic [IDX_W-1:0] tail,
  output logic [IDX_W-1:0] thr,
  output logic             phase,
  output logic             full,
  output logic             thr_hit,
  output logic             stall_pend
);
  logic [IDX_W-1:0] occ_now;
  logic [IDX_W-1:0] tail_nx;
  logic [IDX_W-1:0] occ_after;
  logic             wraps;

  always_comb begin
    occ_now   = IDX_W'(ring_occ(32'(tail), 32'(head), 32'(ents)));
    tail_nx   = IDX_W'(ring_next(32'(tail), 32'(ents)));
    occ_after = IDX_W'(ring_occ(32'(tail_nx), 32'(head), 32'(ents)));
    wraps     = (tail_nx == '0);
    full      = (ents != '0) && (occ_now == ents - IDX_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base       <= '0;
      ents       <= '0;
      head       <= '0;
      tail       <= '0;
      thr        <= '0;
      phase      <= 1'b1;
      thr_hit    <= 1'b0;
      stall_pend <= 1'b0;
    end else begin
      if (we_base_lo) base[31:0]  <= wdata;
      if (we_base_hi) base[63:32] <= wdata;
      if (we_size)    ents        <= wdata[IDX_W+3:4];
      if (we_head)    head        <= wdata[IDX_W-1:0];
      if (we_thr)     thr         <= wdata[IDX_W-1:0];
      if (adv) begin
        tail <= tail_nx;
        if (wraps) phase <= ~phase;
      end
      if (we_head)
        thr_hit <= 1'b0;
      else if (adv && thr != '0 && occ_after >= thr)
        thr_hit <= 1'b1;
      if (stall_mark)
        stall_pend <= 1'b1;
      else if (adv)
        stall_pend <= 1'b0;
    end
  end
endmodule

// File: rtl/nq_ring_writer.sv
module nq_ring_writer
  import nq_pkg::*;
#(
  parameter int          N_SRC      = 3,
  parameter int          N_RING     = 10,
  parameter int          IDX_W      = 16,
  parameter int          RID_W      = 4,
  parameter int          RA_W       = 12,
  parameter logic [31:0] TS_INC_RST = 32'd1,
  localparam int         SW         = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  localparam int         GRP_BASE   = 256,
  localparam int         GRP_STRIDE = 40
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_SRC-1:0]            req_valid,
  output logic [N_SRC-1:0]            req_ready,
  input  logic [N_SRC-1:0][RID_W-1:0] req_ring,
  input  logic [N_SRC-1:0][4:0]       req_kind,
  input  logic [N_SRC-1:0][23:0]      req_pay_lo,
  input  logic [N_SRC-1:0][31:0]      req_pay_hi,
  output logic                        wr_valid,
  input  logic                        wr_ready,
  output logic [63:0]                 wr_addr,
  output logic [127:0]                wr_data,
  input  logic                        rsp_valid,
  input  logic                        rsp_err,
  input  logic                        reg_we,
  input  logic [RA_W-1:0]             reg_addr,
  input  logic [31:0]                 reg_wdata,
  output logic [31:0]                 reg_rdata,
  output logic [8:0]                  irq_o
);
  localparam logic [RA_W-1:0] A_EN    = RA_W'(12'h000);
  localparam logic [RA_W-1:0] A_POL   = RA_W'(12'h004);
  localparam logic [RA_W-1:0] A_STEP  = RA_W'(12'h008);
  localparam logic [RA_W-1:0] A_STS   = RA_W'(12'h00C);
  localparam logic [RA_W-1:0] A_FID   = RA_W'(12'h010);
  localparam logic [RA_W-1:0] A_EAL   = RA_W'(12'h014);
  localparam logic [RA_W-1:0] A_EAH   = RA_W'(12'h018);
  localparam logic [RA_W-1:0] A_TSL   = RA_W'(12'h01C);
  localparam logic [RA_W-1:0] A_TSH   = RA_W'(12'h020);

  // global state
  nq_state_e          st;
  logic [63:0]        ts_q;
  logic [31:0]        step_q;
  logic [N_RING-1:0]  en_q;
  logic [N_RING-1:0]  ovw_q;
  logic               sts_full, sts_dis, sts_axi;
  logic [RID_W-1:0]   full_id_q;
  logic [63:0]        err_addr_q;
  nq_rec_t            cur_rec;
  logic [RID_W-1:0]   cur_ring;
  logic [63:0]        cur_addr;

  // per-ring context outputs
  logic [63:0]        r_base  [N_RING];
  logic [IDX_W-1:0]   r_ents  [N_RING];
  logic [IDX_W-1:0]   r_head  [N_RING];
  logic [IDX_W-1:0]   r_tail  [N_RING];
  logic [IDX_W-1:0]   r_thr   [N_RING];
  logic [N_RING-1:0]  r_phase, r_full, r_thr_hit, r_spend;

  // arbitration
  logic [N_SRC-1:0]   gnt;
  logic [SW-1:0]      sel;
  logic               any_req;
  logic [RID_W-1:0]   sel_ring;
  logic [RID_W-1:0]   ring_i;
  logic               ring_ok;

  // named internal events, also observed by the checker
  logic               ev_drop, ev_stall, ev_take, ev_done;
  logic               head_wr_any;
  logic               sts_clr;

  nq_prio_arb #(.N(N_SRC)) u_arb (
    .req (req_valid),
    .gnt (gnt),
    .idx (sel),
    .any (any_req)
  );

  always_comb begin
    sel_ring = req_ring[sel];
    ring_ok  = (32'(sel_ring) < N_RING);
    ring_i   = ring_ok ? sel_ring : '0;
    ev_drop  = (st == ST_IDLE) && any_req && (!ring_ok || !en_q[ring_i]);
    ev_stall = (st == ST_IDLE) && any_req && ring_ok && en_q[ring_i] &&
               r_full[ring_i] && !ovw_q[ring_i];
    ev_take  = (st == ST_IDLE) && any_req && ring_ok && en_q[ring_i] &&
               !(r_full[ring_i] && !ovw_q[ring_i]);
    ev_done  = (st == ST_RESP) && rsp_valid;
    req_ready = (ev_drop || ev_take) ? gnt : '0;
    sts_clr  = reg_we && (reg_addr == A_STS);
  end

  for (genvar g = 0; g < N_RING; g++) begin : g_ring
    localparam logic [RA_W-1:0] GB = RA_W'(GRP_BASE + g * GRP_STRIDE);
    nq_ring_ctx #(.IDX_W(IDX_W)) u_ctx (
      .clk        (clk),
      .rst_n      (rst_n),
      .wdata      (reg_wdata),
      .we_base_lo (reg_we && reg_addr == GB),
      .we_base_hi (reg_we && reg_addr == GB + RA_W'(4)),
      .we_size    (reg_we && reg_addr == GB + RA_W'(8)),
      .we_head    (reg_we && reg_addr == GB + RA_W'(12)),
      .we_thr     (reg_we && reg_addr == GB + RA_W'(20)),
      .adv        (ev_done && cur_ring == RID_W'(g)),
      .stall_mark (ev_stall && ring_i == RID_W'(g)),
      .base       (r_base[g]),
      .ents       (r_ents[g]),
      .head       (r_head[g]),
      .tail       (r_tail[g]),
      .thr        (r_thr[g]),
      .phase      (r_phase[g]),
      .full       (r_full[g]),
      .thr_hit    (r_thr_hit[g]),
      .stall_pend (r_spend[g])
    );
  end

  // sequencing of one record at a time
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cur_rec  <= '0;
      cur_ring <= '0;
      cur_addr <= '0;
    end else begin
      case (st)
        ST_IDLE: if (ev_take) begin
          cur_rec.stamp      <= ts_q;
          cur_rec.pay_hi     <= req_pay_hi[sel];
          cur_rec.phase      <= r_phase[ring_i];
          cur_rec.stall_flag <= r_spend[ring_i];
          cur_rec.ovw_flag   <= r_full[ring_i];
          cur_rec.kind       <= req_kind[sel];
          cur_rec.pay_lo     <= req_pay_lo[sel];
          cur_ring           <= ring_i;
          cur_addr           <= r_base[ring_i] +
                                (64'(r_tail[ring_i]) << $clog2(REC_BYTES));
          st                 <= ST_ISSUE;
        end
        ST_ISSUE: if (wr_ready) st <= ST_RESP;
        ST_RESP:  if (rsp_valid) st <= ST_IDLE;
        default:  st <= ST_IDLE;
      endcase
    end
  end

  assign wr_valid = (st == ST_ISSUE);
  assign wr_addr  = cur_addr;
  assign wr_data  = cur_rec;

  // timestamp, configuration and status
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ts_q       <= '0;
      step_q     <= TS_INC_RST;
      en_q       <= '1;
      ovw_q      <= '0;
      sts_full   <= 1'b0;
      sts_dis    <= 1'b0;
      sts_axi    <= 1'b0;
      full_id_q  <= '0;
      err_addr_q <= '0;
    end else begin
      ts_q <= ts_q + 64'(step_q);
      if (reg_we && reg_addr == A_STEP) step_q <= reg_wdata;
      if (reg_we && reg_addr == A_EN)   en_q   <= reg_wdata[N_RING-1:0];
      if (reg_we && reg_addr == A_POL)  ovw_q  <= reg_wdata[N_RING-1:0];
      sts_full <= ev_stall | (sts_full & ~(sts_clr & reg_wdata[0]));
      sts_dis  <= ev_drop  | (sts_dis  & ~(sts_clr & reg_wdata[1]));
      sts_axi  <= (ev_done & rsp_err) | (sts_axi & ~(sts_clr & reg_wdata[4]));
      if (ev_stall) full_id_q <= ring_i;
      if (ev_done && rsp_err) err_addr_q <= cur_addr;
    end
  end

  assign irq_o = {2'b00, |r_thr_hit, 1'b0, sts_axi, 2'b00, sts_dis, sts_full};

  // register read and head-write detection
  always_comb begin
    reg_rdata   = '0;
    head_wr_any = 1'b0;
    if (reg_addr == A_EN)   reg_rdata = 32'(en_q);
    if (reg_addr == A_POL)  reg_rdata = 32'(ovw_q);
    if (reg_addr == A_STEP) reg_rdata = step_q;
    if (reg_addr == A_STS)  reg_rdata = 32'({sts_axi, 2'b00, sts_dis, sts_full});
    if (reg_addr == A_FID)  reg_rdata = 32'(full_id_q);
    if (reg_addr == A_EAL)  reg_rdata = err_addr_q[31:0];
    if (reg_addr == A_EAH)  reg_rdata = err_addr_q[63:32];
    if (reg_addr == A_TSL)  reg_rdata = ts_q[31:0];
    if (reg_addr == A_TSH)  reg_rdata = ts_q[63:32];
    for (int i = 0; i < N_RING; i++) begin
      if (reg_addr == RA_W'(GRP_BASE + i * GRP_STRIDE))      reg_rdata = r_base[i][31:0];
      if (reg_addr == RA_W'(GRP_BASE + i * GRP_STRIDE + 4))  reg_rdata = r_base[i][63:32];
      if (reg_addr == RA_W'(GRP_BASE + i * GRP_STRIDE + 8))  reg_rdata = 32'(r_ents[i]) << 4;
      if (reg_addr == RA_W'(GRP_BASE + i * GRP_STRIDE + 12)) reg_rdata = 32'(r_head[i]);
      if (reg_addr == RA_W'(GRP_BASE + i * GRP_STRIDE + 16)) reg_rdata = 32'(r_tail[i]);
      if (reg_addr == RA_W'(GRP_BASE + i * GRP_STRIDE + 20)) reg_rdata = 32'(r_thr[i]);
      if (reg_we && reg_addr == RA_W'(GRP_BASE + i * GRP_STRIDE + 12)) head_wr_any = 1'b1;
    end
  end
endmodule

// File: rtl/nq_ring_writer_chk.sv
module nq_ring_writer_chk #(
  parameter int N_SRC = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] req_valid,
  input logic [N_SRC-1:0] req_ready,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic [63:0]      wr_addr,
  input logic [127:0]     wr_data,
  input logic [8:0]       irq_o,
  input logic             ev_drop,
  input logic             ev_stall,
  input logic             head_wr_any
);
  // R10
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ready));

  // R10
  grant_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready & ~req_valid) == '0);

  // R11
  write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  // R11
  no_take_in_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> req_ready == '0);

  // R4
  drop_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_drop |=> !wr_valid);

  // R5
  full_irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o[0]) |-> $past(ev_stall));

  // R8
  thr_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_o[6]) |-> $past(head_wr_any));
endmodule

bind nq_ring_writer nq_ring_writer_chk #(.N_SRC(N_SRC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .wr_valid    (wr_valid),
  .wr_ready    (wr_ready),
  .wr_addr     (wr_addr),
  .wr_data     (wr_data),
  .irq_o       (irq_o),
  .ev_drop     (ev_drop),
  .ev_stall    (ev_stall),
  .head_wr_any (head_wr_any)
);

// File: tb/nq_ring_writer_tb.sv
`timescale 1ns/1ps
module nq_ring_writer_tb;
  localparam int NS = 3;
  localparam int NR = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [NS-1:0]        req_valid = '0;
  logic [NS-1:0]        req_ready;
  logic [NS-1:0][3:0]   req_ring = '0;
  logic [NS-1:0][4:0]   req_kind = '0;
  logic [NS-1:0][23:0]  req_pay_lo = '0;
  logic [NS-1:0][31:0]  req_pay_hi = '0;
  logic                 wr_valid;
  logic                 wr_ready = 1'b0;
  logic [63:0]          wr_addr;
  logic [127:0]         wr_data;
  logic                 rsp_valid = 1'b0;
  logic                 rsp_err = 1'b0;
  logic                 reg_we = 1'b0;
  logic [11:0]          reg_addr = '0;
  logic [31:0]          reg_wdata = '0;
  logic [31:0]          reg_rdata;
  logic [8:0]           irq_o;

  nq_ring_writer u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_ring(req_ring),
    .req_kind(req_kind), .req_pay_lo(req_pay_lo), .req_pay_hi(req_pay_hi),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_o(irq_o)
  );

  // memory model: alternating ready, response one cycle after acceptance
  logic         err_inject = 1'b0;
  logic [127:0] cap_d [256];
  logic [63:0]  cap_a [256];
  int           cap_n = 0;
  int           rsp_cnt = 0;

  always @(posedge clk) begin
    wr_ready <= ~wr_ready;
    if (rsp_valid) begin
      rsp_valid <= 1'b0;
      rsp_cnt   <= rsp_cnt + 1;
    end
    if (wr_valid && wr_ready) begin
      cap_d[cap_n % 256] <= wr_data;
      cap_a[cap_n % 256] <= wr_addr;
      cap_n     <= cap_n + 1;
      rsp_valid <= 1'b1;
      rsp_err   <= err_inject;
    end
  end

  int n_chk = 0;
  int n_err = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [11:0] ring_reg(input int r, input int off);
    return 12'(256 + r * 40 + off);
  endfunction

  task automatic send(input int s, input int ring, input logic [4:0] kind,
                      input logic [23:0] plo, input logic [31:0] phi,
                      input int maxw, output bit ok);
    @(negedge clk);
    req_ring[s] = 4'(ring); req_kind[s] = kind;
    req_pay_lo[s] = plo; req_pay_hi[s] = phi;
    req_valid[s] = 1'b1;
    ok = 1'b0;
    for (int k = 0; k < maxw; k++) begin
      #1;
      if (req_ready[s]) begin
        ok = 1'b1;
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
    req_valid[s] = 1'b0;
  endtask

  task automatic wait_rsp(input int target);
    for (int k = 0; k < 100 && rsp_cnt < target; k++) @(negedge clk);
  endtask

  function automatic int ents_of(input int r);
    return 3 + (r % 3);
  endfunction

  function automatic logic [63:0] base_of(input int r);
    return {32'(r + 1), 32'(r * 32'h1000)};
  endfunction

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0]  rd, rd2;
    logic [127:0] rec;
    logic [63:0]  last_stamp;
    bit           ok;
    int           target;
    int           cap0;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R13 / R4 / R9 reset state
    reg_rd(12'h000, rd); chk(rd == 32'h3ff, "R4 enable reset", 64'(rd), 64'h3ff);
    reg_rd(12'h00C, rd); chk(rd == 0, "R13 status reset", 64'(rd), 0);
    chk(irq_o == 0, "R13 irq reset", 64'(irq_o), 0);
    reg_rd(ring_reg(3, 16), rd); chk(rd == 0, "R13 tail reset", 64'(rd), 0);
    reg_rd(12'h008, rd); chk(rd == 1, "R9 step reset", 64'(rd), 1);

    // R1 R2 R3 sweep: every ring, two full wraps plus one record
    target = 0;
    last_stamp = '0;
    for (int r = 0; r < NR; r++) begin
      int e;
      e = ents_of(r);
      reg_wr(ring_reg(r, 0), base_of(r)[31:0]);
      reg_wr(ring_reg(r, 4), base_of(r)[63:32]);
      reg_wr(ring_reg(r, 8), 32'(e * 16));
      for (int n = 0; n < 2 * e + 1; n++) begin
        logic [4:0]  kd;
        logic [23:0] plo;
        logic [31:0] phi;
        logic        ph;
        kd  = 5'(r * 3 + n);
        plo = 24'(32'hA50000 + r * 256 + n);
        phi = 32'hC0DE0000 + 32'(r * 16 + n);
        ph  = ((n / e) % 2) == 0;
        send(r % NS, r, kd, plo, phi, 50, ok);
        target++;
        wait_rsp(target);
        rec = cap_d[(cap_n - 1) % 256];
        chk(cap_a[(cap_n - 1) % 256] == base_of(r) + 64'((n % e) * 16),
            "R2 record address", cap_a[(cap_n - 1) % 256], base_of(r) + 64'((n % e) * 16));
        chk(rec[63:0] == {phi, ph, 1'b0, 1'b0, kd, plo}, "R1 record fields",
            rec[63:0], {phi, ph, 1'b0, 1'b0, kd, plo});
        chk(rec[31] == ph, "R3 phase bit", 64'(rec[31]), 64'(ph));
        chk(rec[127:64] > last_stamp, "R9 stamp increases", rec[127:64], last_stamp);
        last_stamp = rec[127:64];
        reg_rd(ring_reg(r, 16), rd);
        chk(rd == 32'((n + 1) % e), "R2 tail advance", 64'(rd), 64'((n + 1) % e));
        reg_wr(ring_reg(r, 12), 32'((n + 1) % e));
      end
    end

    // R5 stall on full ring 4 (4 entries, tail=head=1)
    for (int n = 0; n < 3; n++) begin
      send(0, 4, 5'h4, 24'(n), 32'h44, 50, ok);
      target++;
      wait_rsp(target);
    end
    cap0 = cap_n;
    send(0, 4, 5'h5, 24'h5, 32'h45, 20, ok);
    chk(!ok, "R5 full ring not accepted", 64'(ok), 0);
    chk(cap_n == cap0, "R5 no write while full", 64'(cap_n), 64'(cap0));
    chk(irq_o[0] == 1'b1, "R5 full irq", 64'(irq_o[0]), 1);
    reg_rd(12'h010, rd); chk(rd == 4, "R5 full ring id", 64'(rd), 4);
    reg_rd(ring_reg(4, 16), rd); chk(rd == 0, "R5 tail held", 64'(rd), 0);
    reg_wr(ring_reg(4, 12), 32'd2);
    send(0, 4, 5'h5, 24'h5, 32'h45, 20, ok);
    target++;
    wait_rsp(target);
    rec = cap_d[(cap_n - 1) % 256];
    chk(ok, "R5 accepted after head move", 64'(ok), 1);
    chk(rec[30] == 1'b1, "R5 stall flag in record", 64'(rec[30]), 1);
    chk(rec[31] == 1'b0, "R3 phase after wrap", 64'(rec[31]), 0);
    chk(cap_a[(cap_n - 1) % 256] == base_of(4), "R2 address after wrap",
        cap_a[(cap_n - 1) % 256], base_of(4));
    reg_wr(12'h00C, 32'h1);
    reg_rd(12'h00C, rd); chk(rd[0] == 1'b0, "R12 clear full bit", 64'(rd), 0);
    chk(irq_o[0] == 1'b0, "R12 irq bit0 clear", 64'(irq_o[0]), 0);

    // R6 overwrite on ring 5 (5 entries, tail=head=1)
    reg_wr(12'h004, 32'h20);
    for (int n = 0; n < 4; n++) begin
      send(1, 5, 5'h6, 24'(n), 32'h55, 50, ok);
      target++;
      wait_rsp(target);
      rec = cap_d[(cap_n - 1) % 256];
      chk(rec[29] == 1'b0, "R6 no overwrite flag below full", 64'(rec[29]), 0);
    end
    send(1, 5, 5'h7, 24'h9, 32'h56, 20, ok);
    target++;
    wait_rsp(target);
    rec = cap_d[(cap_n - 1) % 256];
    chk(ok, "R6 full ring accepted", 64'(ok), 1);
    chk(rec[29] == 1'b1, "R6 overwrite flag", 64'(rec[29]), 1);
    chk(irq_o[0] == 1'b0, "R6 no full irq", 64'(irq_o[0]), 0);
    reg_rd(ring_reg(5, 16), rd); chk(rd == 1, "R6 tail past head", 64'(rd), 1);

    // R4 disabled ring 6 and out-of-range ring 12
    reg_wr(12'h000, 32'h3ff & ~32'h40);
    cap0 = cap_n;
    send(2, 6, 5'h8, 24'h1, 32'h66, 20, ok);
    repeat (6) @(negedge clk);
    chk(ok, "R4 disabled ring request accepted", 64'(ok), 1);
    chk(cap_n == cap0, "R4 disabled ring no write", 64'(cap_n), 64'(cap0));
    chk(irq_o[1] == 1'b1, "R4 disabled irq", 64'(irq_o[1]), 1);
    reg_rd(ring_reg(6, 16), rd); chk(rd == 1, "R4 tail unchanged", 64'(rd), 1);
    reg_wr(12'h00C, 32'h2);
    chk(irq_o[1] == 1'b0, "R12 irq bit1 clear", 64'(irq_o[1]), 0);
    send(2, 12, 5'h8, 24'h1, 32'h66, 20, ok);
    repeat (6) @(negedge clk);
    chk(cap_n == cap0 && irq_o[1], "R4 bad ring dropped", 64'(cap_n), 64'(cap0));
    reg_wr(12'h00C, 32'h2);

    // R7 response error on ring 7 (tail=1)
    err_inject = 1'b1;
    send(0, 7, 5'h9, 24'h7, 32'h77, 50, ok);
    target++;
    wait_rsp(target);
    err_inject = 1'b0;
    @(negedge clk);
    chk(irq_o[4] == 1'b1, "R7 error irq", 64'(irq_o[4]), 1);
    reg_rd(12'h014, rd);
    reg_rd(12'h018, rd2);
    chk({rd2, rd} == base_of(7) + 64'd16, "R7 error address", {rd2, rd}, base_of(7) + 64'd16);
    reg_rd(ring_reg(7, 16), rd); chk(rd == 2, "R7 tail still advances", 64'(rd), 2);
    reg_wr(12'h00C, 32'h10);
    chk(irq_o[4] == 1'b0, "R12 irq bit4 clear", 64'(irq_o[4]), 0);

    // R8 threshold on ring 8 (5 entries, tail=head=1), threshold 2
    reg_wr(ring_reg(8, 20), 32'd2);
    send(1, 8, 5'hA, 24'h1, 32'h88, 50, ok);
    target++;
    wait_rsp(target);
    chk(irq_o[6] == 1'b0, "R8 below threshold", 64'(irq_o[6]), 0);
    send(1, 8, 5'hA, 24'h2, 32'h88, 50, ok);
    target++;
    wait_rsp(target);
    chk(irq_o[6] == 1'b1, "R8 threshold reached", 64'(irq_o[6]), 1);
    reg_wr(ring_reg(8, 12), 32'd2);
    chk(irq_o[6] == 1'b0, "R8 head write re-arms", 64'(irq_o[6]), 0);

    // R10 simultaneous requesters on ring 9 (3 entries, tail=head=1)
    begin
      bit a0, a2, d0, d2;
      d0 = 0; d2 = 0;
      @(negedge clk);
      req_ring[0] = 4'd9; req_kind[0] = 5'h11; req_pay_lo[0] = 24'h0; req_pay_hi[0] = 32'h0;
      req_ring[2] = 4'd9; req_kind[2] = 5'h12; req_pay_lo[2] = 24'h0; req_pay_hi[2] = 32'h0;
      req_valid[0] = 1'b1; req_valid[2] = 1'b1;
      for (int k = 0; k < 60 && !(d0 && d2); k++) begin
        #1 a0 = req_ready[0]; a2 = req_ready[2];
        @(negedge clk);
        if (a0) begin req_valid[0] = 1'b0; d0 = 1; end
        if (a2) begin req_valid[2] = 1'b0; d2 = 1; end
      end
      target += 2;
      wait_rsp(target);
      chk(cap_d[(cap_n - 2) % 256][28:24] == 5'h11, "R10 lowest index first",
          64'(cap_d[(cap_n - 2) % 256][28:24]), 64'h11);
      chk(cap_d[(cap_n - 1) % 256][28:24] == 5'h12, "R10 second requester next",
          64'(cap_d[(cap_n - 1) % 256][28:24]), 64'h12);
    end

    // R9 programmable step
    reg_wr(12'h008, 32'd5);
    reg_rd(12'h01C, rd);
    repeat (9) @(negedge clk);
    reg_rd(12'h01C, rd2);
    chk(rd2 - rd == 32'd50, "R9 step per clock", 64'(rd2 - rd), 50);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule